// File: doc/BRIEF.md
# Two-Way Cache Line Maintenance Engine

This block performs single-line maintenance on a small two-way set-associative cache that it holds in internal register arrays. Software sets up three registers: an address register, a value register and a command register. Setting the start bit in the command register launches one operation. The operation is a lookup/read, a write, a clean (write back a dirty line and mark it clean) or an invalidate. The line it acts on is named in one of two ways. Cache mode gives a set index and an explicit way. Physical mode gives an address whose tag is compared against both ways of the indexed set.

Every operation takes exactly two cycles. In the same edge that drops the start bit, the engine stores three status flags in the command register, and these describe the line as it stood before the operation: which way was targeted, whether that line was valid, and whether it was dirty. For every operation except a write, the value register is loaded with the line's prior tag word or data word. A write takes its data from the value register and leaves that register as it was. A clean of a dirty line sends out the line on a one-cycle write-back strobe.

Top module: `lcu_top`

## Requirements
- R1: After reset, the command register and the value register read zero and the write-back strobe is low. Every line is invalid and clean, so a cache-mode read of any line reports the valid and modified status bits (bits 20 and 21) as 0.
- R2: Command register fields are: bit 31 start/busy, bit 27 select (1 = tag word, 0 = data word), bit 26 way, bits 25:24 operation (0 read, 1 write, 2 clean, 3 invalidate), bit 23 mode (1 = physical). Writing bit 31 as 1 starts an operation. Bit 31 then reads 1 for exactly two cycles and clears by itself. Software writes to bits 22:20 have no effect.
- R3: On completion, bit 22 holds the targeted way, bit 21 that line's modified flag and bit 20 its valid flag, all as they were before the operation. In cache mode these come from the addressed way's stored flags, even when the line is invalid.
- R4: In physical mode the set is address bits 5:2 and the tag is address bits 25:6. A way hits when it is valid and its tag is equal. Way 0 wins if both ways hit, and the reported way is the way that hit. A miss reports way 0, valid 0 and modified 0.
- R5: After any operation other than a write, the value register holds the target line's prior contents. With select = 1 it holds the tag word: tag in bits 31:12, modified in bit 1, valid in bit 0, zeros elsewhere. With select = 0 it holds the data word. After a physical-mode miss its contents are undefined.
- R6: A write leaves the value register unchanged. With select = 1 it loads the line's tag, modified and valid flags from the tag-word layout of R5. With select = 0 it loads only the data word.
- R7: When the reported valid bit is 0 the line is left unchanged. The one exception is a cache-mode write, which is applied to an invalid line so that software can load the cache.
- R8: A clean of a valid, dirty line pulses the write-back strobe for one cycle, in the completion cycle, and clears the line's modified flag. The strobe carries address {tag, set, 2'b00} and the line's data. A clean of a clean or invalid line raises no strobe.
- R9: An invalidate of a valid line clears both its valid flag and its modified flag.
- R10: While bit 31 is set, writes to the command, address and value registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write data |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | ADDR_W | Address register write data |
| val_we | input | 1 | Value register write strobe |
| val_wdata | input | DATA_W | Value register write data |
| cmd_rdata | output | 32 | Command register contents, including busy and status |
| val_rdata | output | DATA_W | Value register contents |
| wb_valid | output | 1 | One-cycle write-back strobe |
| wb_addr | output | ADDR_W | Write-back line address |
| wb_data | output | DATA_W | Write-back line data |

## Verification
The bench loads the same tag into both ways of one set to exercise the physical-mode tie. A design that picks the higher way, or that reports the way it was given, fails there. Cleans are issued twice on a dirty line: a missing strobe or a repeated strobe exposes a modified flag that is not cleared, or one cleared too early. Physical-mode writes and invalidates that miss are followed by cache-mode reads, which catches engines that modify lines they never hit. Writes are launched with the value, address and command registers hit again during the busy window, which exposes a write that takes late data, a restart while busy, or a write that clobbers the value register.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  localparam int WAYS = 2;

  localparam int B_GO    = 31;
  localparam int B_TDS   = 27;
  localparam int B_WAY   = 26;
  localparam int B_OP_LO = 24;
  localparam int B_PHYS  = 23;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CLEAN = 2'd2,
    OP_INVAL = 2'd3
  } lcu_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_EXEC = 2'd2
  } lcu_state_e;
endpackage

// File: rtl/lcu_line_store.sv
module lcu_line_store
  import lcu_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SET_W-1:0]               rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
  output logic [WAYS-1:0]                rd_vld,
  output logic [WAYS-1:0]                rd_mod,
  output logic [WAYS-1:0][DATA_W-1:0]    rd_data,
  input  logic [SET_W-1:0]               wr_set,
  input  logic                           wr_way,
  input  logic                           meta_we,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic                           wr_vld,
  input  logic                           wr_mod,
  input  logic                           data_we,
  input  logic [DATA_W-1:0]              wr_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   vld_r;
    logic [SETS-1:0]   mod_r;
    logic              sel;

    assign sel = (wr_way == 1'(w));

    // flags need a reset; tag and data stay plain memories
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= '0;
        mod_r <= '0;
      end else if (meta_we && sel) begin
        vld_r[wr_set] <= wr_vld;
        mod_r[wr_set] <= wr_mod;
      end
    end

    always_ff @(posedge clk) begin
      if (meta_we && sel) tag_mem[wr_set] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (data_we && sel) data_mem[wr_set] <= wr_data;
    end

    assign rd_tag[w]  = tag_mem[rd_set];
    assign rd_data[w] = data_mem[rd_set];
    assign rd_vld[w]  = vld_r[rd_set];
    assign rd_mod[w]  = mod_r[rd_set];
  end
endmodule

// File: rtl/lcu_way_match.sv
module lcu_way_match
  import lcu_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic [WAYS-1:0]            rd_vld,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       any_hit,
  output logic                       hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == req_tag);
  end

  assign any_hit = |hit_vec;

  // lowest-numbered hitting way wins
  always_comb begin
    hit_way = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_way = 1'(i);
    end
  end
endmodule

// File: rtl/lcu_top.sv
module lcu_top
  import lcu_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              val_we,
  input  logic [DATA_W-1:0] val_wdata,
  output logic [31:0]       cmd_rdata,
  output logic [DATA_W-1:0] val_rdata,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int SET_W   = $clog2(SETS);
  localparam int OFF_W   = $clog2(DATA_W / 8);
  localparam int LINE_AW = TAG_W + SET_W + OFF_W;
  localparam int PAD_W   = DATA_W - TAG_W - 2;

  lcu_state_e        state_q;
  logic              go_q, tds_q, way_q, phys_q;
  lcu_op_e           op_q;
  logic              st_way_q, st_mod_q, st_vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] val_q;

  logic              t_way, t_vld, t_mod;
  logic [TAG_W-1:0]  t_tag;
  logic [DATA_W-1:0] t_data;

  logic              wb_valid_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;
  logic [WAYS-1:0]   rd_vld, rd_mod, hit_vec;
  logic              any_hit, hit_way, sel_way;

  logic              exec, do_line, meta_we, data_we, wr_vld, wr_mod;
  logic [TAG_W-1:0]  wr_tag;

  logic unused_bits;
  assign unused_bits = ^{addr_q[ADDR_W-1:LINE_AW], addr_q[OFF_W-1:0],
                         cmd_wdata[30:28], cmd_wdata[22:0], val_q[DATA_W-TAG_W-1:2]};

  assign set_idx = addr_q[OFF_W +: SET_W];
  assign req_tag = addr_q[OFF_W + SET_W +: TAG_W];

  lcu_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .rd_set(set_idx),
    .rd_tag(rd_tag), .rd_vld(rd_vld), .rd_mod(rd_mod), .rd_data(rd_data),
    .wr_set(set_idx), .wr_way(t_way), .meta_we(meta_we), .wr_tag(wr_tag),
    .wr_vld(wr_vld), .wr_mod(wr_mod), .data_we(data_we), .wr_data(val_q)
  );

  lcu_way_match #(.TAG_W(TAG_W)) u_match (
    .rd_tag(rd_tag), .rd_vld(rd_vld), .req_tag(req_tag),
    .hit_vec(hit_vec), .any_hit(any_hit), .hit_way(hit_way)
  );

  assign sel_way = phys_q ? hit_way : way_q;

  // line update in the completion cycle
  assign exec    = (state_q == S_EXEC);
  assign do_line = exec && (t_vld || (op_q == OP_WRITE && !phys_q));

  always_comb begin
    meta_we = 1'b0;
    data_we = 1'b0;
    wr_tag  = t_tag;
    wr_vld  = t_vld;
    wr_mod  = t_mod;
    if (do_line) begin
      unique case (op_q)
        OP_WRITE: begin
          if (tds_q) begin
            meta_we = 1'b1;
            wr_tag  = val_q[DATA_W-1 -: TAG_W];
            wr_vld  = val_q[0];
            wr_mod  = val_q[1];
          end else begin
            data_we = 1'b1;
          end
        end
        OP_CLEAN: begin
          meta_we = t_mod;
          wr_mod  = 1'b0;
        end
        OP_INVAL: begin
          meta_we = 1'b1;
          wr_vld  = 1'b0;
          wr_mod  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      go_q     <= 1'b0;
      tds_q    <= 1'b0;
      way_q    <= 1'b0;
      phys_q   <= 1'b0;
      op_q     <= OP_READ;
      st_way_q <= 1'b0;
      st_mod_q <= 1'b0;
      st_vld_q <= 1'b0;
      addr_q   <= '0;
      val_q    <= '0;
      t_way    <= 1'b0;
      t_vld    <= 1'b0;
      t_mod    <= 1'b0;
      t_tag    <= '0;
      t_data   <= '0;
      wb_valid_q <= 1'b0;
      wb_addr_q  <= '0;
      wb_data_q  <= '0;
    end else begin
      wb_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (addr_we) addr_q <= addr_wdata;
          if (val_we)  val_q  <= val_wdata;
          if (cmd_we) begin
            tds_q  <= cmd_wdata[B_TDS];
            way_q  <= cmd_wdata[B_WAY];
            op_q   <= lcu_op_e'(cmd_wdata[B_OP_LO +: 2]);
            phys_q <= cmd_wdata[B_PHYS];
            if (cmd_wdata[B_GO]) begin
              go_q    <= 1'b1;
              state_q <= S_LOOK;
            end
          end
        end
        S_LOOK: begin
          t_way   <= sel_way;
          t_vld   <= phys_q ? any_hit : rd_vld[way_q];
          t_mod   <= phys_q ? (any_hit && rd_mod[hit_way]) : rd_mod[way_q];
          t_tag   <= rd_tag[sel_way];
          t_data  <= rd_data[sel_way];
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          go_q     <= 1'b0;
          st_way_q <= t_way;
          st_mod_q <= t_mod;
          st_vld_q <= t_vld;
          if (op_q != OP_WRITE)
            val_q <= tds_q ? {t_tag, {PAD_W{1'b0}}, t_mod, t_vld} : t_data;
          if (op_q == OP_CLEAN && t_vld && t_mod) begin
            wb_valid_q <= 1'b1;
            wb_addr_q  <= ADDR_W'({t_tag, set_idx, {OFF_W{1'b0}}});
            wb_data_q  <= t_data;
          end
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_rdata = {go_q, 3'b000, tds_q, way_q, op_q, phys_q,
                      st_way_q, st_mod_q, st_vld_q, 20'd0};
  assign val_rdata = val_q;
  assign wb_valid  = wb_valid_q;
  assign wb_addr   = wb_addr_q;
  assign wb_data   = wb_data_q;

  // R2: busy stays up two cycles, then drops
  assert_go_two_cycles_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(go_q) |=> go_q ##1 !go_q) else $error("busy window not two cycles");

  // R4: both ways hit -> way 0 recorded
  assert_way0_priority_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_LOOK && phys_q && hit_vec[0]) |=> (t_way == 1'b0))
    else $error("way 0 priority lost");

  // R6: a write never alters the value register
  assert_write_keeps_value_R6: assert property (@(posedge clk) disable iff (rst)
    (exec && op_q == OP_WRITE) |=> $stable(val_q)) else $error("value changed by write");

  // R7: lines change only in the completion cycle
  assert_line_write_exec_R7: assert property (@(posedge clk) disable iff (rst)
    (meta_we || data_we) |-> (state_q == S_EXEC)) else $error("line write outside exec");

  // R8: write-back only for a valid dirty clean, single cycle
  assert_wb_dirty_R8: assert property (@(posedge clk) disable iff (rst)
    wb_valid_q |-> (st_vld_q && st_mod_q && op_q == OP_CLEAN)) else $error("stray write-back");
  assert_wb_single_R8: assert property (@(posedge clk) disable iff (rst)
    wb_valid_q |=> !wb_valid_q) else $error("write-back longer than one cycle");

  // R10: address register frozen while busy
  assert_busy_addr_R10: assert property (@(posedge clk) disable iff (rst)
    go_q |=> $stable(addr_q)) else $error("address changed while busy");
endmodule

// File: tb/lcu_top_tb.sv
module lcu_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0, addr_we = 1'b0, val_we = 1'b0;
  logic [31:0] cmd_wdata = '0, addr_wdata = '0, val_wdata = '0;
  logic [31:0] cmd_rdata, val_rdata, wb_addr, wb_data;
  logic        wb_valid;

  int checks = 0;
  int fails  = 0;
  bit skip_val = 1'b0;

  logic [19:0] m_tag  [2][16];
  logic [31:0] m_data [2][16];
  bit          m_vld  [2][16];
  bit          m_mod  [2][16];

  always #10 clk = ~clk;

  lcu_top u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .val_we(val_we), .val_wdata(val_wdata),
    .cmd_rdata(cmd_rdata), .val_rdata(val_rdata), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tag_word(input logic [19:0] t, input bit m, input bit v);
    return {t, 10'd0, m, v};
  endfunction

  function automatic logic [31:0] mk_addr(input logic [19:0] t, input logic [3:0] s);
    return {6'd0, t, s, 2'b00};
  endfunction

  task automatic run_cmd(input logic [1:0] op, input bit phys, input bit way, input bit tds,
                         input logic [31:0] addr, input logic [31:0] val, input bit poke);
    logic [3:0]  s;
    logic [19:0] tg;
    bit h0, h1, ev, em, ew, ewb, b1, b2;
    logic [31:0] eval, ewa, ewd, cw;
    s  = addr[5:2];
    tg = addr[25:6];
    if (phys) begin
      h0 = m_vld[0][s] && (m_tag[0][s] == tg);
      h1 = m_vld[1][s] && (m_tag[1][s] == tg);
      ev = h0 || h1;
      ew = h0 ? 1'b0 : h1;
      em = ev ? m_mod[ew][s] : 1'b0;
    end else begin
      ew = way;
      ev = m_vld[way][s];
      em = m_mod[way][s];
    end
    if (op == 2'd1) eval = val;
    else eval = tds ? tag_word(m_tag[ew][s], em, ev) : m_data[ew][s];
    ewb = (op == 2'd2) && ev && em;
    ewa = mk_addr(m_tag[ew][s], s);
    ewd = m_data[ew][s];

    @(negedge clk);
    addr_we = 1'b1; addr_wdata = addr; val_we = 1'b1; val_wdata = val;
    @(negedge clk);
    addr_we = 1'b0; val_we = 1'b0;
    cw = (32'd1 << 31) | (32'(tds) << 27) | (32'(way) << 26) | (32'(op) << 24) | (32'(phys) << 23);
    cmd_we = 1'b1; cmd_wdata = cw | 32'h0070_0000;
    @(negedge clk);
    cmd_we = 1'b0;
    b1 = cmd_rdata[31];
    if (poke) begin
      cmd_we = 1'b1; cmd_wdata = ~cw | (32'd1 << 31);
      addr_we = 1'b1; addr_wdata = ~addr;
      val_we = 1'b1; val_wdata = ~val;
    end
    @(negedge clk);
    cmd_we = 1'b0; addr_we = 1'b0; val_we = 1'b0;
    b2 = cmd_rdata[31];
    @(negedge clk);
    chk(b1 && b2 && !cmd_rdata[31], "R2", "busy pattern", {29'd0, b1, b2, cmd_rdata[31]}, 32'd6);
    chk(cmd_rdata[27:23] == {tds, way, op, phys}, poke ? "R10" : "R2", "fields",
        32'(cmd_rdata[27:23]), 32'({tds, way, op, phys}));
    chk(cmd_rdata[22:20] == {ew, em, ev}, phys ? "R4" : "R3", "status",
        32'(cmd_rdata[22:20]), 32'({ew, em, ev}));
    if (!skip_val && !(phys && !ev && op != 2'd1))
      chk(val_rdata == eval, op == 2'd1 ? "R6" : "R5", "value", val_rdata, eval);
    chk(wb_valid == ewb, "R8", "strobe", 32'(wb_valid), 32'(ewb));
    if (ewb) begin
      chk(wb_addr == ewa, "R8", "wb addr", wb_addr, ewa);
      chk(wb_data == ewd, "R8", "wb data", wb_data, ewd);
    end
    @(negedge clk);
    chk(!wb_valid, "R8", "strobe drop", 32'(wb_valid), 32'd0);

    if (ev || (op == 2'd1 && !phys)) begin
      case (op)
        2'd1: if (tds) begin
                m_tag[ew][s] = val[31:12]; m_vld[ew][s] = val[0]; m_mod[ew][s] = val[1];
              end else m_data[ew][s] = val;
        2'd2: m_mod[ew][s] = 1'b0;
        2'd3: begin m_vld[ew][s] = 1'b0; m_mod[ew][s] = 1'b0; end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] t;
    logic [3:0]  s;
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 16; i++) begin
        m_vld[w][i] = 1'b0; m_mod[w][i] = 1'b0; m_tag[w][i] = '0; m_data[w][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_rdata == 32'd0, "R1", "cmd reset", cmd_rdata, 32'd0);
    chk(val_rdata == 32'd0, "R1", "value reset", val_rdata, 32'd0);
    chk(!wb_valid, "R1", "strobe reset", 32'(wb_valid), 32'd0);

    // R1: lines invalid after reset
    skip_val = 1'b1;
    run_cmd(2'd0, 1'b0, 1'b0, 1'b1, mk_addr(20'h0, 4'd3), 32'd0, 1'b0);
    run_cmd(2'd0, 1'b0, 1'b1, 1'b0, mk_addr(20'h0, 4'd9), 32'd0, 1'b0);
    skip_val = 1'b0;

    // fill every line through cache-mode writes (R7 exception)
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 16; i++) begin
        run_cmd(2'd1, 1'b0, 1'(w), 1'b1, mk_addr(20'h0, 4'(i)),
                tag_word(20'($urandom), 1'b0, 1'b0), 1'b0);
        run_cmd(2'd1, 1'b0, 1'(w), 1'b0, mk_addr(20'h0, 4'(i)), $urandom, 1'b0);
      end

    // R4: same tag valid in both ways -> way 0
    run_cmd(2'd1, 1'b0, 1'b0, 1'b1, mk_addr(0, 4'd5), tag_word(20'hABCDE, 1'b0, 1'b1), 1'b0);
    run_cmd(2'd1, 1'b0, 1'b1, 1'b1, mk_addr(0, 4'd5), tag_word(20'hABCDE, 1'b1, 1'b1), 1'b0);
    run_cmd(2'd0, 1'b1, 1'b1, 1'b0, mk_addr(20'hABCDE, 4'd5), 32'd0, 1'b0);
    // R9: invalidate way 0 by address, then way 1 hits
    run_cmd(2'd3, 1'b1, 1'b0, 1'b0, mk_addr(20'hABCDE, 4'd5), 32'd0, 1'b0);
    run_cmd(2'd0, 1'b1, 1'b0, 1'b1, mk_addr(20'hABCDE, 4'd5), 32'd0, 1'b0);
    run_cmd(2'd0, 1'b0, 1'b0, 1'b1, mk_addr(0, 4'd5), 32'd0, 1'b0);
    // R8: clean dirty line twice
    run_cmd(2'd1, 1'b0, 1'b1, 1'b1, mk_addr(0, 4'd7), tag_word(20'h13579, 1'b1, 1'b1), 1'b0);
    run_cmd(2'd2, 1'b1, 1'b0, 1'b0, mk_addr(20'h13579, 4'd7), 32'd0, 1'b0);
    run_cmd(2'd2, 1'b1, 1'b0, 1'b0, mk_addr(20'h13579, 4'd7), 32'd0, 1'b0);
    // R7: physical-mode write miss and invalidate of invalid line change nothing
    run_cmd(2'd1, 1'b1, 1'b0, 1'b1, mk_addr(20'h55555, 4'd2), tag_word(20'h55555, 1'b1, 1'b1), 1'b0);
    run_cmd(2'd0, 1'b0, 1'b0, 1'b1, mk_addr(0, 4'd2), 32'd0, 1'b0);
    run_cmd(2'd3, 1'b0, 1'b1, 1'b1, mk_addr(0, 4'd2), 32'd0, 1'b0);
    run_cmd(2'd0, 1'b0, 1'b1, 1'b1, mk_addr(0, 4'd2), 32'd0, 1'b0);
    // R10: register writes during busy ignored
    run_cmd(2'd1, 1'b0, 1'b0, 1'b0, mk_addr(0, 4'd11), 32'hCAFE_F00D, 1'b1);
    run_cmd(2'd0, 1'b0, 1'b0, 1'b0, mk_addr(0, 4'd11), 32'd0, 1'b0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      s = 4'($urandom_range(0, 15));
      t = ($urandom_range(0, 9) < 6) ? m_tag[$urandom_range(0, 1)][s] : 20'($urandom);
      v = $urandom;
      v[0] = ($urandom_range(0, 3) != 0);
      run_cmd(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), mk_addr(t, s), v, ($urandom_range(0, 9) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule